// File: doc/BRIEF.md
# Mode-Sequenced SEC-DED Memory Word Protector

This block sits between a processor and a memory and protects 16-bit data words with a 6-bit check word. The check word comes from a modified Hamming code. Each data bit has a distinct odd-weight parity column of weight three or more. Each check bit has a weight-one column. Both the data port and the check port are bidirectional. Each is modelled as a separate input bus, output bus and output enable; the pads themselves lie outside the block.

Two mode-select inputs sequence the work. On a memory write, the block drives the generated check word towards the memory. On a memory read, it takes in the 22-bit stored word and latches it. It then raises a single-error flag and a double-error flag. In the correction mode it drives the repaired data word and the 6-bit syndrome back out. A single data-bit error is repaired. A single check-bit error is flagged, but the data passes through unchanged. Any two flipped bits raise both flags.

Top module: `edac_sec_ded`

## Requirements
- R1: With mode {sel_hi,sel_lo}=00, chk_oe=1, dat_oe=0, both flags are 0, and chk_out is the even-parity check word of dat_in. Data bit i uses column i of the list of 6-bit values of odd weight 3 or more, ordered by weight and then by value. Check bit j is the XOR of the data bits whose column has bit j set.
- R2: With mode 01, dat_oe=0, chk_oe=0 and both flags are 0.
- R3: With mode 11, each rising clock edge latches dat_in and chk_in. Two edges after entry, the flags reflect the latched word. dat_oe=0 and chk_oe=0.
- R4: With mode 10, dat_oe=1 and chk_oe=1. chk_out is the syndrome: the check word recomputed from the latched data, XOR the latched check word.
- R5: For an error-free latched word, both flags are 0, the syndrome is 0 and dat_out equals the latched data.
- R6: If exactly one data bit i is flipped, err_single=1 and err_double=0. The syndrome equals column i, and dat_out is the original data.
- R7: If exactly one check bit j is flipped, err_single=1 and err_double=0. The syndrome equals 1<<j, and dat_out equals the latched data unchanged.
- R8: If any two bits of the 22 are flipped, err_single=1 and err_double=1. Any odd-weight syndrome that matches no column also counts as a double error.
- R9: While the mode stays 10, dat_out, chk_out and the flags hold still; changes on dat_in and chk_in have no effect.
- R10: After reset, the latched word and the results are zero. Mode 10 then shows dat_out=0, chk_out=0 and both flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_hi | input | 1 | Upper mode select |
| sel_lo | input | 1 | Lower mode select |
| dat_in | input | 16 | Data arriving from the bus or the memory |
| dat_out | output | 16 | Corrected data driven out |
| dat_oe | output | 1 | Data port output enable |
| chk_in | input | 6 | Check word arriving from the memory |
| chk_out | output | 6 | Generated check word or syndrome |
| chk_oe | output | 1 | Check port output enable |
| err_single | output | 1 | At least one error detected |
| err_double | output | 1 | Uncorrectable error detected |

## Verification
Two functions can meet in one cycle: the correction outputs are held from an earlier latch while new data already shows on dat_in. The bench provokes this by driving fresh random words onto dat_in and chk_in during the correction mode. It then judges that dat_out, chk_out and the flags still match the word latched before (R9). Random words with zero, one or two injected flips, together with directed flips at every data and check position, are compared against syndromes that bench functions compute.

// File: rtl/edac_pkg.sv
package edac_pkg;
  parameter int DW = 16;
  parameter int CW = 6;
  parameter int SW = DW + CW;

  typedef logic [DW-1:0] data_t;
  typedef logic [CW-1:0] chk_t;

  typedef enum logic [1:0] {
    M_WRITE = 2'b00,
    M_READ  = 2'b01,
    M_CORR  = 2'b10,
    M_LATCH = 2'b11
  } mode_e;

  function automatic int popc(chk_t v);
    int n = 0;
    for (int b = 0; b < CW; b++) n += int'(v[b]);
    return n;
  endfunction

  // column of data bit idx: odd weight >= 3, ordered by weight then value
  function automatic chk_t data_col(int idx);
    chk_t r = '0;
    int k = 0;
    for (int w = 3; w <= CW; w += 2)
      for (int v = 0; v < (1 << CW); v++)
        if (popc(chk_t'(v)) == w) begin
          if (k == idx) r = chk_t'(v);
          k++;
        end
    return r;
  endfunction

  function automatic chk_t make_check(data_t d);
    chk_t c = '0;
    for (int i = 0; i < DW; i++)
      if (d[i]) c ^= data_col(i);
    return c;
  endfunction
endpackage

// File: rtl/edac_encoder.sv
module edac_encoder
  import edac_pkg::*;
(
  input  data_t d,
  output chk_t  c
);
  // one parity tree per check bit over the data bits whose column has that bit
  for (genvar j = 0; j < CW; j++) begin : g_par
    data_t mask;
    for (genvar i = 0; i < DW; i++) begin : g_m
      localparam chk_t COL = data_col(i);
      assign mask[i] = COL[j];
    end
    assign c[j] = ^(d & mask);
  end
endmodule

// File: rtl/edac_decoder.sv
module edac_decoder
  import edac_pkg::*;
(
  input  data_t d,
  input  chk_t  c,
  output chk_t  syn,
  output data_t fixed,
  output logic  any_err,
  output logic  uncorr
);
  chk_t  recomp;
  data_t hit;
  logic  chk_hit;

  edac_encoder u_enc (.d(d), .c(recomp));

  assign syn = recomp ^ c;

  for (genvar i = 0; i < DW; i++) begin : g_hit
    localparam chk_t COL = data_col(i);
    assign hit[i] = (syn == COL);
  end

  assign chk_hit = (popc(syn) == 1);
  assign fixed   = d ^ hit;
  assign any_err = (syn != '0);
  assign uncorr  = any_err && !(|hit) && !chk_hit;

  always_comb begin
    // R6
    hit_onehot_chk: assert ($onehot0(hit));
  end
endmodule

// File: rtl/edac_store.sv
module edac_store
  import edac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cap,
  input  data_t d_in,
  input  chk_t  c_in,
  output data_t d_q,
  output chk_t  c_q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      d_q <= '0;
      c_q <= '0;
    end else if (cap) begin
      d_q <= d_in;
      c_q <= c_in;
    end

  // R3
  latch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (d_q == $past(d_in) && c_q == $past(c_in)));
endmodule

// File: rtl/edac_sec_ded.sv
module edac_sec_ded
  import edac_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_hi,
  input  logic          sel_lo,
  input  logic [DW-1:0] dat_in,
  output logic [DW-1:0] dat_out,
  output logic          dat_oe,
  input  logic [CW-1:0] chk_in,
  output logic [CW-1:0] chk_out,
  output logic          chk_oe,
  output logic          err_single,
  output logic          err_double
);
  mode_e mode;
  assign mode = mode_e'({sel_hi, sel_lo});

  data_t lat_d, dec_fix, r_fix;
  chk_t  lat_c, wr_chk, dec_syn, r_syn;
  logic  dec_any, dec_unc, r_sef, r_def;
  logic  in_write, in_corr, flags_en;

  assign in_write = (mode == M_WRITE);
  assign in_corr  = (mode == M_CORR);
  assign flags_en = sel_hi;

  edac_encoder u_wr (.d(dat_in), .c(wr_chk));

  edac_store u_st (
    .clk(clk), .rst_n(rst_n), .cap(mode == M_LATCH),
    .d_in(dat_in), .c_in(chk_in), .d_q(lat_d), .c_q(lat_c)
  );

  edac_decoder u_dec (
    .d(lat_d), .c(lat_c), .syn(dec_syn), .fixed(dec_fix),
    .any_err(dec_any), .uncorr(dec_unc)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_fix <= '0;
      r_syn <= '0;
      r_sef <= 1'b0;
      r_def <= 1'b0;
    end else begin
      r_fix <= dec_fix;
      r_syn <= dec_syn;
      r_sef <= dec_any;
      r_def <= dec_unc;
    end

  assign dat_out    = r_fix;
  assign dat_oe     = in_corr;
  assign chk_out    = in_write ? wr_chk : r_syn;
  assign chk_oe     = in_write || in_corr;
  assign err_single = flags_en && r_sef;
  assign err_double = flags_en && r_def;

  // R8
  dbl_implies_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_double |-> err_single);

  // R2
  flags_quiet_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_hi |-> (!err_single && !err_double && !dat_oe));

  // R5
  clean_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_corr && !err_single) |-> (dat_out == lat_d && chk_out == '0));

  // R9
  corr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_corr && $past(in_corr) && $past(in_corr, 2)) |->
      ($stable(dat_out) && $stable(chk_out) && $stable(err_double)));
endmodule

// File: tb/sim_edac_sec_ded.sv
module sim_edac_sec_ded;
  logic clk = 0, rst_n = 0, sel_hi = 0, sel_lo = 0;
  logic [15:0] dat_in = '0, dat_out;
  logic [5:0]  chk_in = '0, chk_out;
  logic dat_oe, chk_oe, err_single, err_double;
  int errors = 0, checks = 0;
  logic [5:0] cols [16];

  always #2 clk = ~clk;

  edac_sec_ded u0 (.*);

  function automatic int wt(logic [5:0] v);
    return $countones(v);
  endfunction

  function automatic logic [5:0] benc(logic [15:0] d);
    logic [5:0] c = '0;
    for (int j = 0; j < 6; j++)
      for (int i = 0; i < 16; i++)
        if (cols[i][j]) c[j] = c[j] ^ d[i];
    return c;
  endfunction

  task automatic ck(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic setm(logic [1:0] m);
    {sel_hi, sel_lo} = m;
  endtask

  // present word, latch it, move to correction mode, check outputs
  task automatic run_read(logic [15:0] d0, logic [15:0] fd, logic [5:0] fc, int nerr, string tag);
    logic [5:0] c0 = benc(d0);
    logic [15:0] sd = d0 ^ fd;
    logic [5:0]  sc = c0 ^ fc;
    logic [5:0]  syn = benc(sd) ^ sc;
    logic [15:0] exp_d = sd;
    for (int i = 0; i < 16; i++) if (syn == cols[i]) exp_d[i] = ~exp_d[i];
    @(negedge clk); setm(2'b01); dat_in = sd; chk_in = sc;
    #1;
    ck(!dat_oe && !chk_oe && !err_single && !err_double, "R2 read mode", {dat_oe, chk_oe, err_single, err_double}, 0);
    @(negedge clk); setm(2'b11);
    @(negedge clk); @(negedge clk);
    #1;
    ck(!dat_oe && !chk_oe, "R3 latch oe", {dat_oe, chk_oe}, 0);
    ck(err_single == (nerr > 0) && err_double == (nerr > 1), {"R3 ", tag, " flags"},
       {err_single, err_double}, {1'(nerr > 0), 1'(nerr > 1)});
    @(negedge clk); setm(2'b10);
    #1;
    ck(dat_oe && chk_oe, "R4 corr oe", {dat_oe, chk_oe}, 2'b11);
    ck(chk_out == syn, {"R4 ", tag, " syndrome"}, chk_out, syn);
    ck(err_single == (nerr > 0) && err_double == (nerr > 1), {tag, " flags"},
       {err_single, err_double}, {1'(nerr > 0), 1'(nerr > 1)});
    if (nerr < 2) ck(dat_out == exp_d, {tag, " data"}, dat_out, exp_d);
    // R9: new inputs during correction must not disturb outputs
    dat_in = 16'($urandom); chk_in = 6'($urandom);
    @(negedge clk); #1;
    ck(chk_out == syn && err_single == (nerr > 0) && err_double == (nerr > 1), "R9 hold syn/flags", chk_out, syn);
    if (nerr < 2) ck(dat_out == exp_d, "R9 hold data", dat_out, exp_d);
  endtask

  initial begin
    int k = 0;
    for (int w = 3; w <= 6; w += 2)
      for (int v = 0; v < 64; v++)
        if (wt(6'(v)) == w && k < 16) begin cols[k] = 6'(v); k++; end
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    setm(2'b10);
    #1;
    ck(dat_out == 0 && chk_out == 0 && !err_single && !err_double, "R10 reset state", {dat_out, chk_out}, 0);

    // R1 write mode, directed and random
    for (int n = 0; n < 40; n++) begin
      logic [15:0] d = (n == 0) ? 16'h0000 : (n == 1) ? 16'hFFFF : 16'($urandom);
      @(negedge clk); setm(2'b00); dat_in = d; #1;
      ck(chk_out == benc(d) && chk_oe && !dat_oe && !err_single && !err_double, "R1 write check word", chk_out, benc(d));
    end

    // R5 clean words
    run_read(16'h0000, 0, 0, 0, "R5 zero");
    for (int n = 0; n < 10; n++) run_read(16'($urandom), 0, 0, 0, "R5 clean");
    // R6 every data bit
    for (int i = 0; i < 16; i++) run_read(16'($urandom), 16'(1) << i, 0, 1, "R6 data flip");
    // R7 every check bit
    for (int j = 0; j < 6; j++) run_read(16'($urandom), 0, 6'(1) << j, 1, "R7 check flip");
    // R8 doubles: data/data, data/check, check/check, random
    run_read(16'hA5A5, 16'h0003, 0, 2, "R8 dd");
    run_read(16'h1234, 16'h8000, 6'h01, 2, "R8 dc");
    run_read(16'hFFFF, 0, 6'h21, 2, "R8 cc");
    for (int n = 0; n < 60; n++) begin
      int a = $urandom_range(0, 21), b;
      logic [21:0] f;
      do b = $urandom_range(0, 21); while (b == a);
      f = (22'(1) << a) | (22'(1) << b);
      run_read(16'($urandom), f[15:0], f[21:16], 2, "R8 rand");
    end
    // mixed random single/no errors
    for (int n = 0; n < 60; n++) begin
      int p = $urandom_range(0, 22);
      logic [21:0] f = (p == 22) ? 22'(0) : (22'(1) << p);
      run_read(16'($urandom), f[15:0], f[21:16], (p == 22) ? 0 : 1, (p < 16) ? "R6 rand" : "R7 rand");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule